// File: doc/BRIEF.md
# AC-link GPIO Status Shadow Register

This block listens to the serial input direction of an AC-link and keeps a local copy of the codec GPIO status word that arrives in slot 12 of every frame. A rising edge on the frame sync input marks the first bit of a frame. After that edge the block counts bit clocks through the 16-bit tag and twelve 20-bit slots, MSB first, so that the frame is 256 bits long. The 20 bits of slot 12 occupy frame bit positions 236 to 255.

A host reads the modem codec GPIO status register at address 0x54 through a small read port. The answer comes from the stored copy one clock later, and nothing is sent over the serial link. The lowest bit of slot 12 reports a GPIO input event. It sets a sticky interrupt flag, which the host clears by writing a one to the same address. Every other slot, including the reserved slots 7 to 11, is discarded.

Top module: `ac_gpio_shadow`

## Requirements
- R1: While reset is asserted and after it is released, the stored status word reads as zero, the interrupt flag is low and the read-valid strobe is low, until a complete frame arrives.
- R2: A low-to-high transition of `sync` always starts a new frame at bit 0, even in the middle of a frame. A partly received frame that is cut short this way leaves the stored status word unchanged.
- R3: Frame bits 236 to 255 form slot 12, MSB first, and bit 236 is slot bit 19. The stored word is replaced only on the clock edge that samples frame bit 255. A read issued on that same edge, or earlier in the frame, returns the previous word.
- R4: A read (`host_rd` high) of address 0x54 gives `rd_valid` high on the next cycle, with `rd_nack` low. `rd_data` then equals slot bits 19:4 of the last complete frame.
- R5: A read of any other address gives `rd_valid` and `rd_nack` high on the next cycle, with `rd_data` zero.
- R6: When a complete frame carries slot-12 bit 0 set, `gpio_irq` is high from the next cycle on. It stays high through later frames whose bit 0 is clear.
- R7: A write (`host_wr` high) to address 0x54 with `host_wbit` = 1 clears `gpio_irq`. A write with `host_wbit` = 0, or a write to any other address, leaves it unchanged. If a set and a clear fall on the same edge, the set wins.
- R8: The content of the tag and of slots 1 to 11, including reserved slots 7 to 11, never affects the stored word or the interrupt flag.
- R9: After bit 255, the block ignores the input stream until the next rising `sync`. A further 256 bits without a sync edge change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitclk | input | 1 | Serial bit clock; clocks the whole block |
| rst_n | input | 1 | Active-low synchronous reset |
| sync | input | 1 | Frame sync; its rising edge marks frame bit 0 |
| sdata_in | input | 1 | Serial input data from the codec, sampled on the rising edge of `bitclk` |
| host_rd | input | 1 | Read request for `host_addr` |
| host_wr | input | 1 | Write request for `host_addr` |
| host_addr | input | 7 | Codec register address |
| host_wbit | input | 1 | Write data bit 0; a one clears the interrupt flag |
| rd_data | output | 16 | GPIO status returned by a read |
| rd_valid | output | 1 | One-cycle strobe, one cycle after `host_rd` |
| rd_nack | output | 1 | Marks a read that the shadow does not serve |
| gpio_irq | output | 1 | Sticky GPIO input event flag |

## Verification
A single one-hot bit is walked through all twenty positions of slot 12 while every other slot carries ones. This separates a wrong bit order, an off-by-one slot window and leakage from neighbouring slots, and it shows that only slot bit 0 raises the interrupt. Further frames fill the other slots with zeros, alternating bits and a mixed pattern. Reads placed at bit 245 and at bit 255 of a frame show that the word never changes part way through. A frame cut off at bit 246 by an early sync, and 256 bits sent without any sync, must leave the stored word alone. Clear writes are tried with the wrong data bit, with the wrong address, and on the same edge as an interrupt-setting frame.

// File: rtl/ac_shadow_pkg.sv
package ac_shadow_pkg;
  localparam int FRAME_BITS  = 256;
  localparam int TAG_BITS    = 16;
  localparam int SLOT_BITS   = 20;
  localparam int GPIO_W      = 16;
  localparam int STATUS_SLOT = 12;
  localparam int CNT_W       = $clog2(FRAME_BITS);

  typedef logic [SLOT_BITS-1:0] slot_t;
  typedef logic [CNT_W-1:0]     bit_idx_t;

  // first frame bit of a 20-bit data slot (slot numbering starts at 1)
  function automatic int slot_first_bit(input int slot);
    return TAG_BITS + (slot - 1) * SLOT_BITS;
  endfunction

  function automatic int slot_last_bit(input int slot);
    return slot_first_bit(slot) + SLOT_BITS - 1;
  endfunction

  // GPIO pin status lives in the upper 16 bits of the slot
  function automatic logic [GPIO_W-1:0] gpio_field(input slot_t s);
    return s[SLOT_BITS-1 -: GPIO_W];
  endfunction
endpackage

// File: rtl/ac_frame_tracker.sv
module ac_frame_tracker
  import ac_shadow_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sync,
  output logic     frame_start,
  output logic     bit_live,
  output bit_idx_t bit_idx
);
  localparam bit_idx_t LAST_IDX = bit_idx_t'(FRAME_BITS - 1);

  logic     sync_q;
  logic     active_q;
  bit_idx_t cnt_q;

  assign frame_start = sync & ~sync_q;
  assign bit_live    = frame_start | active_q;
  assign bit_idx     = frame_start ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= 1'b0;
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      sync_q <= sync;
      if (bit_live) begin
        if (bit_idx == LAST_IDX) begin
          active_q <= 1'b0;
        end else begin
          active_q <= 1'b1;
          cnt_q    <= bit_idx + bit_idx_t'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ac_slot_capture.sv
module ac_slot_capture
  import ac_shadow_pkg::*;
#(
  parameter int SLOT_SEL = STATUS_SLOT
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bit_live,
  input  bit_idx_t bit_idx,
  input  logic     sdata,
  output logic     slot_done,
  output slot_t    shadow
);
  localparam bit_idx_t FIRST = bit_idx_t'(slot_first_bit(SLOT_SEL));
  localparam bit_idx_t LAST  = bit_idx_t'(slot_last_bit(SLOT_SEL));

  logic [SLOT_BITS-2:0] shift_q;
  slot_t                assembled;
  logic                 in_slot;

  assign in_slot   = bit_live && (bit_idx >= FIRST) && (bit_idx <= LAST);
  assign slot_done = bit_live && (bit_idx == LAST);
  assign assembled = {shift_q, sdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      shadow  <= '0;
    end else begin
      if (in_slot)   shift_q <= assembled[SLOT_BITS-2:0];
      if (slot_done) shadow  <= assembled;
    end
  end
endmodule

// File: rtl/ac_gpio_host.sv
module ac_gpio_host
  import ac_shadow_pkg::*;
#(
  parameter int              ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 7'h54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GPIO_W-1:0] status_field,
  input  logic              irq_set,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wbit,
  output logic [GPIO_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_nack,
  output logic              gpio_irq
);
  logic addr_hit;
  logic irq_clr;

  assign addr_hit = (host_addr == STATUS_ADDR);
  assign irq_clr  = host_wr & addr_hit & host_wbit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      rd_nack  <= 1'b0;
      gpio_irq <= 1'b0;
    end else begin
      rd_valid <= host_rd;
      rd_nack  <= host_rd & ~addr_hit;
      rd_data  <= (host_rd & addr_hit) ? status_field : '0;
      if (irq_set)      gpio_irq <= 1'b1;
      else if (irq_clr) gpio_irq <= 1'b0;
    end
  end
endmodule

// File: rtl/ac_gpio_shadow.sv
module ac_gpio_shadow
  import ac_shadow_pkg::*;
#(
  parameter int              ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 7'h54
) (
  input  logic              bitclk,
  input  logic              rst_n,
  input  logic              sync,
  input  logic              sdata_in,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wbit,
  output logic [GPIO_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_nack,
  output logic              gpio_irq
);
  logic     frame_start;
  logic     bit_live;
  bit_idx_t bit_idx;
  logic     slot_done;
  slot_t    shadow;
  logic     irq_set;

  ac_frame_tracker u_trk (
    .clk         (bitclk),
    .rst_n       (rst_n),
    .sync        (sync),
    .frame_start (frame_start),
    .bit_live    (bit_live),
    .bit_idx     (bit_idx)
  );

  ac_slot_capture #(.SLOT_SEL(STATUS_SLOT)) u_cap (
    .clk       (bitclk),
    .rst_n     (rst_n),
    .bit_live  (bit_live),
    .bit_idx   (bit_idx),
    .sdata     (sdata_in),
    .slot_done (slot_done),
    .shadow    (shadow)
  );

  // slot bit 0 is the last bit of the slot on the wire
  assign irq_set = slot_done & sdata_in;

  ac_gpio_host #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_host (
    .clk          (bitclk),
    .rst_n        (rst_n),
    .status_field (gpio_field(shadow)),
    .irq_set      (irq_set),
    .host_rd      (host_rd),
    .host_wr      (host_wr),
    .host_addr    (host_addr),
    .host_wbit    (host_wbit),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid),
    .rd_nack      (rd_nack),
    .gpio_irq     (gpio_irq)
  );
endmodule

// File: rtl/ac_shadow_chk.sv
module ac_shadow_chk
  import ac_shadow_pkg::*;
#(
  parameter int              ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 7'h54
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sdata_in,
  input logic              frame_start,
  input logic              bit_live,
  input bit_idx_t          bit_idx,
  input logic              slot_done,
  input slot_t             shadow,
  input logic              host_rd,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wbit,
  input logic [GPIO_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              rd_nack,
  input logic              gpio_irq
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!gpio_irq && !rd_valid && shadow == '0));

  p_frame_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (bit_live && bit_idx == bit_idx_t'(1)));

  p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_done |=> $stable(shadow));

  p_rd_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> rd_valid);

  p_no_spurious_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> !rd_valid);

  p_miss_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr != STATUS_ADDR) |=> (rd_nack && rd_data == '0));

  p_irq_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_done && sdata_in) |=> gpio_irq);

  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_irq && !(host_wr && host_addr == STATUS_ADDR && host_wbit)) |=> gpio_irq);

  p_frame_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_live && bit_idx == bit_idx_t'(FRAME_BITS - 1)) |=> (!bit_live || frame_start));
endmodule

bind ac_gpio_shadow ac_shadow_chk #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_chk (
  .clk         (bitclk),
  .rst_n       (rst_n),
  .sdata_in    (sdata_in),
  .frame_start (frame_start),
  .bit_live    (bit_live),
  .bit_idx     (bit_idx),
  .slot_done   (slot_done),
  .shadow      (shadow),
  .host_rd     (host_rd),
  .host_wr     (host_wr),
  .host_addr   (host_addr),
  .host_wbit   (host_wbit),
  .rd_data     (rd_data),
  .rd_valid    (rd_valid),
  .rd_nack     (rd_nack),
  .gpio_irq    (gpio_irq)
);

// File: tb/tb_ac_gpio_shadow.sv
module tb_ac_gpio_shadow;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic        sdata = 1'b0;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic [6:0]  host_addr = 7'h00;
  logic        host_wbit = 1'b0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        rd_nack;
  logic        gpio_irq;

  int total = 0;
  int fails = 0;
  logic [19:0] exp_word = '0;
  logic        exp_irq  = 1'b0;

  always #4 clk = ~clk;

  ac_gpio_shadow dut (
    .bitclk(clk), .rst_n(rst_n), .sync(sync), .sdata_in(sdata),
    .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr), .host_wbit(host_wbit),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_nack(rd_nack), .gpio_irq(gpio_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic fill_bit(input int mode, input int k);
    case (mode)
      0:       return 1'b0;
      1:       return 1'b1;
      2:       return k[0];
      default: return ((k * 7) >> 2) % 2 == 1;
    endcase
  endfunction

  // frame bit k of slot 12 (k in 236..255) carries slot bit 255-k
  task automatic send_frame(input logic [19:0] s12, input int mode, input int nbits,
                            input int rd_at, input int wr_at);
    logic        pend = 1'b0;
    logic [15:0] old_field = exp_word[19:4];
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk);
      if (pend) begin
        check("R3 mid-frame read valid", {31'd0, rd_valid}, 32'd1);
        check("R3 mid-frame read keeps old word", {16'd0, rd_data}, {16'd0, old_field});
        pend = 1'b0;
      end
      sync      = (k < 16);
      sdata     = (k >= 236) ? s12[255 - k] : fill_bit(mode, k);
      host_rd   = (k == rd_at);
      host_wr   = (k == wr_at);
      host_addr = 7'h54;
      host_wbit = 1'b1;
      if (k == rd_at) pend = 1'b1;
    end
    @(negedge clk);
    if (pend) begin
      check("R3 last-bit read valid", {31'd0, rd_valid}, 32'd1);
      check("R3 last-bit read keeps old word", {16'd0, rd_data}, {16'd0, old_field});
    end
    sync = 1'b0; sdata = 1'b0; host_rd = 1'b0; host_wr = 1'b0; host_wbit = 1'b0;
    if (wr_at >= 0 && wr_at < nbits) exp_irq = 1'b0;
    if (nbits == 256) begin
      exp_word = s12;
      if (s12[0]) exp_irq = 1'b1;
    end
  endtask

  task automatic read_reg(input string req, input logic [6:0] a,
                          input logic exp_nack, input logic [15:0] exp_d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    check(req, {29'd0, rd_valid, rd_nack, 1'b0}, {29'd0, 1'b1, exp_nack, 1'b0});
    check(req, {16'd0, rd_data}, {16'd0, exp_d});
  endtask

  task automatic write_reg(input logic [6:0] a, input logic wb);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wbit = wb;
    @(negedge clk);
    host_wr = 1'b0; host_wbit = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset irq low", {31'd0, gpio_irq}, 32'd0);
    check("R1 reset no valid", {31'd0, rd_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    read_reg("R1 R4 word zero after reset", 7'h54, 1'b0, 16'h0000);
    read_reg("R5 other address nack", 7'h26, 1'b1, 16'h0000);
    read_reg("R5 neighbour address nack", 7'h55, 1'b1, 16'h0000);

    // R3 R4 R8: walk a one through slot bits 19..1, other slots all ones
    for (int i = 19; i >= 1; i--) begin
      send_frame(20'(1) << i, 1, 256, -1, -1);
      read_reg("R3 R4 R8 walking one", 7'h54, 1'b0, exp_word[19:4]);
      check("R8 irq untouched by other slots", {31'd0, gpio_irq}, {31'd0, exp_irq});
    end
    send_frame(20'h00001, 1, 256, -1, -1);
    check("R6 slot bit 0 raises irq", {31'd0, gpio_irq}, 32'd1);
    read_reg("R4 bit 0 not in read field", 7'h54, 1'b0, 16'h0000);

    send_frame(20'hA5A50, 2, 256, 245, -1);
    read_reg("R4 alternating fill", 7'h54, 1'b0, 16'hA5A5);
    check("R6 irq sticky", {31'd0, gpio_irq}, 32'd1);
    send_frame(20'h3C3CE, 3, 256, 255, -1);
    read_reg("R4 mixed fill", 7'h54, 1'b0, 16'h3C3C);
    check("R6 irq sticky second frame", {31'd0, gpio_irq}, 32'd1);

    write_reg(7'h54, 1'b0);
    check("R7 wbit zero ignored", {31'd0, gpio_irq}, 32'd1);
    write_reg(7'h26, 1'b1);
    check("R7 other address ignored", {31'd0, gpio_irq}, 32'd1);
    write_reg(7'h54, 1'b1);
    check("R7 write one clears", {31'd0, gpio_irq}, 32'd0);

    send_frame(20'hFFFFF, 0, 256, -1, 255);
    check("R7 set wins over clear", {31'd0, gpio_irq}, 32'd1);
    send_frame(20'h12340, 0, 256, -1, 100);
    check("R7 clear mid-frame", {31'd0, gpio_irq}, 32'd0);
    read_reg("R4 zero fill", 7'h54, 1'b0, 16'h1234);

    // R2: frame cut off inside slot 12 by a new sync
    send_frame(20'hFFFFF, 1, 246, -1, -1);
    read_reg("R2 aborted frame leaves word", 7'h54, 1'b0, 16'h1234);
    send_frame(20'h9876E, 0, 256, -1, -1);
    read_reg("R2 restarted frame captured", 7'h54, 1'b0, 16'h9876);
    check("R6 R2 irq from restarted frame stays clear", {31'd0, gpio_irq}, 32'd0);

    // R9: 256 bits with no sync edge
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      sync = 1'b0; sdata = 1'b1;
    end
    @(negedge clk);
    sdata = 1'b0;
    read_reg("R9 no sync no capture", 7'h54, 1'b0, 16'h9876);
    check("R9 no sync no irq", {31'd0, gpio_irq}, 32'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule